// File: doc/BRIEF.md
# Zone Sparsifier with Multi-Write FIFO

The block takes a 32-bit slice of a pixel column once per clock and splits it into eight 4-pixel zones. Each zone with at least one set pixel becomes one hit word. A hit word carries the zone's index within the slice, the column address and the raw 4-bit pattern. All hit words found in one cycle are written into a small FIFO in that same cycle. The FIFO takes up to nine words per cycle and gives out one word per cycle.

A scan-start strobe adds a scan-header word carrying an 8-bit time stamp ahead of that cycle's hits. In the stream, this header divides the hits of one column sweep from those of the next. The consumer drains the FIFO through a valid/ready pair. The head word is shown as soon as it is stored, so there is no extra output register. The column sweep that drives the input and any merging further downstream are handled outside the block.

Top module: `zone_sparsifier`

## Requirements
- R1: When `pix_valid` is high, each 4-bit zone of `pix_data` (zone z = bits [4z+3:4z]) that has a nonzero value produces exactly one hit word. Zones that are all zero produce nothing, and when `pix_valid` is low `pix_data` is ignored.
- R2: A hit word has bit 13 = 0, bits [12:10] = zone index z, bits [9:4] = `col_addr`, and bits [3:0] = the zone's pattern.
- R3: All words produced in one input cycle are stored at the next clock edge. `fill_level` shows them one cycle after the inputs are presented.
- R4: When `scan_start` is high, a scan-header word is stored with bit 13 = 1, bits [12:8] = 0 and bits [7:0] = `scan_ts`. It is placed ahead of any hit words from the same cycle.
- R5: Words leave in the order they were stored. Within one cycle the order is the scan header first, then hit words in ascending zone index.
- R6: The FIFO holds 8 words, and `fill_level` gives the number of stored words (0 to 8).
- R7: `out_valid` is high whenever the FIFO holds a word, and `out_word` is the oldest word. A word leaves only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_word` holds steady.
- R8: If a cycle produces more words than there are free slots, the words that come earliest in the R5 order are kept and the rest are dropped. `overflow` then rises and stays high until reset.
- R9: After reset the FIFO is empty, `out_valid` is low, `fill_level` is 0 and `overflow` is low.
- R10: A slot freed by a pop in a given cycle can take a new word in that same cycle. When the FIFO is full, a pop plus one new hit leaves it full with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | `pix_data` holds a column slice this cycle |
| pix_data | input | 32 | Pixel slice, eight 4-bit zones |
| col_addr | input | 6 | Column address of the slice |
| scan_start | input | 1 | A new scan begins this cycle; add a scan-header word |
| scan_ts | input | 8 | Time stamp for the scan-header word |
| out_ready | input | 1 | Consumer accepts `out_word` |
| out_valid | output | 1 | FIFO not empty |
| out_word | output | 14 | Oldest stored word |
| fill_level | output | 4 | Number of stored words |
| overflow | output | 1 | Sticky flag: words were dropped |

## Verification
The bench builds the block with its default parameters: a 32-bit slice, 4-bit zones, an 8-entry FIFO and an 8-bit time stamp. With these values a single cycle can produce nine words, one more than the FIFO holds. So full-width bursts, partial acceptance at overflow and push-while-full-with-pop can all be reached in a few cycles. A queue model predicts the head word, the fill level, the valid flag and the overflow flag on every clock. Directed cases pin down the word formats and the ordering, and a long random phase with sparse slices and a random `out_ready` covers the rest.

// File: rtl/szf_pkg.sv
// Shared constants for the zone sparsifier.
// Assumes: bit 13 of every output word is the word-type flag.
package szf_pkg;
    localparam logic FLAG_HIT = 1'b0;
    localparam logic FLAG_SOS = 1'b1;
endpackage

// File: rtl/szf_zone_encoder.sv
// Zone encoder: splits one pixel slice into zones and forms a hit word per
// non-empty zone, all in the same cycle.
// Assumes: slice width is NZONES*ZONE_W; zone z owns bits [z*ZONE_W +: ZONE_W].
module szf_zone_encoder #(
    parameter  int ZONE_W = 4,
    parameter  int NZONES = 8,
    parameter  int COL_W  = 6,
    localparam int ZIDX_W = $clog2(NZONES),
    localparam int WORD_W = 1 + ZIDX_W + COL_W + ZONE_W
) (
    input  logic                             slice_valid,
    input  logic [NZONES*ZONE_W-1:0]         slice,
    input  logic [COL_W-1:0]                 col,
    output logic [NZONES-1:0]                zone_req,
    output logic [NZONES-1:0][WORD_W-1:0]    zone_word
);
    // One encoder per zone: request flag and formatted word.
    for (genvar z = 0; z < NZONES; z++) begin : g_zone
        logic [ZONE_W-1:0] nib;
        assign nib          = slice[z*ZONE_W +: ZONE_W];
        assign zone_req[z]  = slice_valid && (nib != '0);
        assign zone_word[z] = {szf_pkg::FLAG_HIT, ZIDX_W'(z), col, nib};
    end
endmodule

// File: rtl/szf_slot_allocator.sv
// Slot allocator: gives each requesting source its position among this
// cycle's writes (prefix count in source order) and the total request count.
// Assumes: source 0 has the highest precedence.
module szf_slot_allocator #(
    parameter  int NSRC  = 9,
    localparam int POS_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]             req,
    output logic [NSRC-1:0][POS_W-1:0]  pos,
    output logic [POS_W-1:0]            total
);
    // Running prefix sum over the request vector.
    always_comb begin
        logic [POS_W-1:0] run;
        run = '0;
        for (int i = 0; i < NSRC; i++) begin
            pos[i] = run;
            run    = run + POS_W'(req[i]);
        end
        total = run;
    end
endmodule

// File: rtl/szf_multi_write_fifo.sv
// Multi-write FIFO: stores up to NSRC words per cycle at positions from the
// allocator and gives out one word per cycle with a flow-through head.
// A pop in a cycle frees its slot for writes in that cycle. Excess words
// (highest positions) are dropped and a sticky overflow flag is set.
// Assumes: DEPTH is a power of two.
module szf_multi_write_fifo #(
    parameter  int WORD_W = 14,
    parameter  int DEPTH  = 8,
    parameter  int NSRC   = 9,
    localparam int POS_W  = $clog2(NSRC + 1),
    localparam int AW     = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SUM_W  = ((CNT_W > POS_W) ? CNT_W : POS_W) + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NSRC-1:0]                 req,
    input  logic [NSRC-1:0][POS_W-1:0]      pos,
    input  logic [POS_W-1:0]                total,
    input  logic [NSRC-1:0][WORD_W-1:0]     words,
    input  logic                            pop_ready,
    output logic                            out_valid,
    output logic [WORD_W-1:0]               out_word,
    output logic [CNT_W-1:0]                fill,
    output logic                            overflow
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop, drop;
    logic [SUM_W-1:0]  free_w, accept;

    // Free space counts the slot released by this cycle's pop.
    always_comb begin
        pop    = (count != '0) && pop_ready;
        free_w = SUM_W'(DEPTH) - SUM_W'(count) + SUM_W'(pop);
        drop   = SUM_W'(total) > free_w;
        accept = drop ? free_w : SUM_W'(total);
    end

    // Storage: each accepted source lands at write pointer plus its position.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (SUM_W'(pos[i]) < free_w)) begin
                mem[wr_ptr + AW'(pos[i])] <= words[i];
            end
        end
    end

    // Pointers, occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + AW'(accept);
            rd_ptr <= rd_ptr + AW'(pop);
            count  <= CNT_W'(SUM_W'(count) - SUM_W'(pop) + accept);
            if (drop) begin
                overflow <= 1'b1;
            end
        end
    end

    assign out_valid = (count != '0);
    assign out_word  = mem[rd_ptr];
    assign fill      = count;
endmodule

// File: rtl/zone_sparsifier.sv
// Zone sparsifier top: encodes the non-empty zones of a pixel slice plus an
// optional scan-header word, and pushes all of them into a multi-write FIFO
// in one cycle. Source 0 is the scan header; sources 1..NZONES are zones.
// Assumes: TS_W fits below the type flag; DEPTH is a power of two.
module zone_sparsifier #(
    parameter  int PIX_W  = 32,
    parameter  int ZONE_W = 4,
    parameter  int COL_W  = 6,
    parameter  int TS_W   = 8,
    parameter  int DEPTH  = 8,
    localparam int NZONES = PIX_W / ZONE_W,
    localparam int ZIDX_W = $clog2(NZONES),
    localparam int WORD_W = 1 + ZIDX_W + COL_W + ZONE_W,
    localparam int NSRC   = NZONES + 1,
    localparam int POS_W  = $clog2(NSRC + 1),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PAD_W  = WORD_W - 1 - TS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic [COL_W-1:0]   col_addr,
    input  logic               scan_start,
    input  logic [TS_W-1:0]    scan_ts,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_word,
    output logic [CNT_W-1:0]   fill_level,
    output logic               overflow
);
    logic [NZONES-1:0]              zone_req;
    logic [NZONES-1:0][WORD_W-1:0]  zone_word;
    logic [NSRC-1:0]                src_req;
    logic [NSRC-1:0][WORD_W-1:0]    src_word;
    logic [NSRC-1:0][POS_W-1:0]     src_pos;
    logic [POS_W-1:0]               src_total;

    szf_zone_encoder #(
        .ZONE_W (ZONE_W),
        .NZONES (NZONES),
        .COL_W  (COL_W)
    ) u_enc (
        .slice_valid (pix_valid),
        .slice       (pix_data),
        .col         (col_addr),
        .zone_req    (zone_req),
        .zone_word   (zone_word)
    );

    // Source list: scan header first, then zones in ascending index.
    always_comb begin
        src_req[0]  = scan_start;
        src_word[0] = {szf_pkg::FLAG_SOS, {PAD_W{1'b0}}, scan_ts};
        for (int z = 0; z < NZONES; z++) begin
            src_req[z+1]  = zone_req[z];
            src_word[z+1] = zone_word[z];
        end
    end

    szf_slot_allocator #(
        .NSRC (NSRC)
    ) u_alloc (
        .req   (src_req),
        .pos   (src_pos),
        .total (src_total)
    );

    szf_multi_write_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .NSRC   (NSRC)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (src_req),
        .pos       (src_pos),
        .total     (src_total),
        .words     (src_word),
        .pop_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .fill      (fill_level),
        .overflow  (overflow)
    );
endmodule

// File: rtl/zone_sparsifier_chk.sv
// Checker for the zone sparsifier: port-level properties on occupancy,
// output hold, overflow behaviour and hit-word content. Bound to the top.
module zone_sparsifier_chk #(
    parameter int WORD_W = 14,
    parameter int ZONE_W = 4,
    parameter int CNT_W  = 4,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              scan_start,
    input logic              out_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic [CNT_W-1:0]  fill_level,
    input logic              overflow
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH));                                       // R6
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));       // R7
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid && !scan_start && out_valid && out_ready
        |=> fill_level == $past(fill_level) - CNT_W'(1));                  // R7
    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid && !scan_start && !(out_valid && out_ready)
        |=> $stable(fill_level));                                           // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                             // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(pix_valid || scan_start));                // R8
    AST_HIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_word[WORD_W-1] |-> out_word[ZONE_W-1:0] != '0);  // R1
endmodule

bind zone_sparsifier zone_sparsifier_chk #(
    .WORD_W (WORD_W),
    .ZONE_W (ZONE_W),
    .CNT_W  (CNT_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .scan_start (scan_start),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .fill_level (fill_level),
    .overflow   (overflow)
);

// File: tb/zone_sparsifier_tb.sv
// Bench: queue-based reference model compared on every clock, plus directed
// checks of word formats, ordering, overflow and same-cycle pop/push.
module zone_sparsifier_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_valid;
    logic [31:0] pix_data;
    logic [5:0]  col_addr;
    logic        scan_start;
    logic [7:0]  scan_ts;
    logic        out_ready;
    logic        out_valid;
    logic [13:0] out_word;
    logic [3:0]  fill_level;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [13:0] q[$];
    bit          m_ovf;

    always #10 clk = ~clk;

    zone_sparsifier u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .col_addr   (col_addr),
        .scan_start (scan_start),
        .scan_ts    (scan_ts),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .fill_level (fill_level),
        .overflow   (overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference update for one clock edge, using the inputs held over it.
    task automatic model_edge();
        logic [13:0] list[$];
        int free;
        if (q.size() > 0 && out_ready) void'(q.pop_front());
        free = 8 - q.size();
        if (scan_start) list.push_back({1'b1, 5'b0, scan_ts});
        if (pix_valid) begin
            for (int z = 0; z < 8; z++) begin
                if (pix_data[z*4 +: 4] != 4'h0)
                    list.push_back({1'b0, 3'(z), col_addr, pix_data[z*4 +: 4]});
            end
        end
        foreach (list[k]) begin
            if (free > 0) begin
                q.push_back(list[k]);
                free--;
            end else begin
                m_ovf = 1'b1;
            end
        end
    endtask

    task automatic compare();
        chk("R7 valid", int'(out_valid), int'(q.size() > 0));
        if (q.size() > 0) chk("R5 head word", int'(out_word), int'(q[0]));
        chk("R6 fill", int'(fill_level), q.size());
        chk("R8 overflow", int'(overflow), int'(m_ovf));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        pix_valid  = 1'b0;
        scan_start = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        out_ready = 1'b0;
        repeat (2) @(posedge clk);
        q.delete();
        m_ovf = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 valid after reset", int'(out_valid), 0);
        chk("R9 fill after reset", int'(fill_level), 0);
        chk("R9 overflow after reset", int'(overflow), 0);
    endtask

    initial begin
        pix_data = '0;
        col_addr = '0;
        scan_ts  = '0;
        do_reset();

        // R2: one zone, format of hit word
        out_ready = 1'b0;
        pix_valid = 1'b1; pix_data = 32'h0000_0050; col_addr = 6'h2A;
        step();
        chk("R2 hit word", int'(out_word), 'h06A5);
        chk("R3 fill after one cycle", int'(fill_level), 1);

        // R1: empty zones and ignored data
        pix_data = 32'h0;
        step();
        chk("R1 all-zero slice", int'(fill_level), 1);
        pix_valid = 1'b0; pix_data = 32'hFFFF_FFFF;
        step();
        chk("R1 pix_valid low", int'(fill_level), 1);
        out_ready = 1'b1;
        repeat (2) step();

        // R4, R5: header with hits in the same cycle
        out_ready = 1'b0;
        scan_start = 1'b1; scan_ts = 8'hA5;
        pix_valid = 1'b1; pix_data = 32'h0F00_00F0; col_addr = 6'h03;
        step();
        chk("R4 header word first", int'(out_word), 'h20A5);
        chk("R3 fill three words", int'(fill_level), 3);
        idle();
        out_ready = 1'b1;
        step();
        chk("R5 zone1 after header", int'(out_word), {1'b0, 3'd1, 6'h03, 4'hF});
        repeat (3) step();

        // R8: partial acceptance then sticky flag
        out_ready = 1'b0;
        pix_valid = 1'b1; pix_data = 32'h0001_1111; col_addr = 6'h11;
        step();
        scan_start = 1'b1; scan_ts = 8'h3C; pix_data = 32'hFFFF_FFFF;
        step();
        chk("R8 overflow raised", int'(overflow), 1);
        chk("R6 full", int'(fill_level), 8);
        idle();
        repeat (3) step();
        out_ready = 1'b1;
        repeat (10) step();
        chk("R8 overflow sticky", int'(overflow), 1);
        do_reset();

        // R10: pop and push in the same cycle while full
        out_ready = 1'b0;
        pix_valid = 1'b1; pix_data = 32'hFFFF_FFFF; col_addr = 6'h05;
        step();
        chk("R10 filled", int'(fill_level), 8);
        out_ready = 1'b1; pix_data = 32'h0000_0001; col_addr = 6'h03;
        step();
        chk("R10 still full", int'(fill_level), 8);
        chk("R10 no overflow", int'(overflow), 0);

        // Random traffic against the model
        for (int n = 0; n < 800; n++) begin
            pix_valid  = ($urandom % 10) < 7;
            pix_data   = $urandom & $urandom & $urandom;
            col_addr   = 6'($urandom);
            scan_start = ($urandom % 10) == 0;
            scan_ts    = 8'($urandom);
            out_ready  = ($urandom % 10) < 6;
            step();
        end
        idle();
        out_ready = 1'b1;
        repeat (10) step();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule